// File: doc/BRIEF.md
# Overlapped Register Window File

This block is a register file for a processor that gives each procedure its own set of 32 logical registers without copying anything on a call. The physical storage is split into a group of global registers seen by every procedure and eight rotating windows. A 3-bit window pointer selects the active window. A call moves the pointer down by one and a return moves it up by one, modulo 8. Each window's outgoing parameter group sits on the same storage as the incoming parameter group of the window below it, so arguments written by a caller are already in place when the callee starts, and results come back the same way.

Logical registers 0 to 9 are global. Registers 10 to 15 are the incoming group, shared with the caller. Registers 16 to 25 are local. Registers 26 to 31 are the outgoing group, shared with the callee. With ten globals and sixteen distinct registers per window, the physical file has 138 entries. Two combinational read ports and one clocked write port take 5-bit logical numbers. The block keeps a count of outstanding calls. When a call would need a ninth window, or a return arrives with no call outstanding, it flags the condition and leaves the pointer unchanged, so that a spill or fill handler can take over.

Top module: `rwin_file`

## Requirements
- R1: After reset the window pointer is 0, every register reads 0, and both flags are low.
- R2: Logical registers 0 to 9 name the same storage in every window.
- R3: When `call_req` alone is high, the pointer decreases by one at the clock edge. When `ret_req` alone is high, the pointer increases by one. When neither is high, the pointer is unchanged.
- R4: The caller's logical registers 26+k (k = 0..5) are the same storage as the callee's logical registers 10+k, in both directions.
- R5: Logical registers 16 to 25 are private to their window. A write to one of them in one window leaves the same numbers in every other window unchanged.
- R6: A call made while 7 calls are outstanding (8 windows in use) raises `win_ovf` in that same cycle and leaves the pointer and the call count unchanged.
- R7: A return made while no call is outstanding raises `win_unf` in that same cycle and leaves the pointer unchanged.
- R8: The two read ports are combinational and independent. A write becomes visible on the read ports after the rising edge on which it is taken.
- R9: A write in the same cycle as a call or a return goes to the window that was active before the pointer moves.
- R10: The pointer wraps modulo 8, so a call from window 0 selects window 7.
- R11: A cycle with `call_req` and `ret_req` both high leaves the pointer and the call count unchanged, and raises neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_sel | input | 5 | Logical register number for read port A |
| ra_data | output | 32 | Read port A data (combinational) |
| rb_sel | input | 5 | Logical register number for read port B |
| rb_data | output | 32 | Read port B data (combinational) |
| we | input | 1 | Write enable |
| wsel | input | 5 | Logical register number to write |
| wdata | input | 32 | Write data |
| call_req | input | 1 | Procedure call: move to the next window down |
| ret_req | input | 1 | Procedure return: move back up one window |
| win_ptr | output | 3 | Current window pointer |
| win_ovf | output | 1 | Call refused because all windows are in use |
| win_unf | output | 1 | Return refused because no call is outstanding |

## Verification
If the pointer is wrong, `win_ptr` shows it on the cycle right after the offending edge. A read of a shared or local register then returns another window's data on the first access. If the call count drifts, nothing is visible until a boundary is reached. The count is therefore exercised all the way to a refused call at full depth and back down to a refused return at zero depth, and the flags and a pointer that holds still are checked at both ends. A fault in the mapping stays hidden until a value written in one window is read from a neighbouring one. For that reason, parameters, results and locals are each written on one side of a call and read back on the other side.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
    // default geometry of the windowed file
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_NWIN   = 8;
    localparam int unsigned DEF_NGLOB  = 10;
    localparam int unsigned DEF_NOVL   = 6;
    localparam int unsigned DEF_NLOC   = 10;

    // pointer movement requested in one cycle, encoded as {call, ret}
    typedef enum logic [1:0] {
        WMOVE_NONE = 2'b00,
        WMOVE_RET  = 2'b01,
        WMOVE_CALL = 2'b10,
        WMOVE_BOTH = 2'b11
    } wmove_e;
endpackage

// File: rtl/rwin_map.sv
// Logical register number plus window pointer -> physical index.
// Physical layout: globals first, then per window a block of
// locals followed by that window's outgoing (callee-shared) group.
module rwin_map #(
    parameter int unsigned NWIN  = 8,
    parameter int unsigned NGLOB = 10,
    parameter int unsigned NOVL  = 6,
    parameter int unsigned NLOC  = 10,
    parameter int unsigned AW    = 5,
    parameter int unsigned PW    = 8,
    parameter int unsigned WPW   = 3
) (
    input  logic [WPW-1:0] cwp,
    input  logic [AW-1:0]  lsel,
    output logic [PW-1:0]  psel
);
    localparam int WSZ     = int'(NLOC + NOVL);
    localparam int IN_END  = int'(NGLOB + NOVL);
    localparam int LOC_END = IN_END + int'(NLOC);

    int l;
    int w;
    int off;

    always_comb begin
        l = int'(lsel);
        w = int'(cwp);
        if (l < int'(NGLOB)) begin
            off = l;
        end else if (l < IN_END) begin
            // incoming group lives in the caller's (pointer + 1) outgoing slot
            off = int'(NGLOB) + ((w + 1) % int'(NWIN)) * WSZ + int'(NLOC) + (l - int'(NGLOB));
        end else if (l < LOC_END) begin
            off = int'(NGLOB) + w * WSZ + (l - IN_END);
        end else begin
            off = int'(NGLOB) + w * WSZ + int'(NLOC) + (l - LOC_END);
        end
        psel = PW'(off);
    end
endmodule

// File: rtl/rwin_ptr.sv
// Window pointer and call-depth tracking.
module rwin_ptr
    import rwin_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    parameter int unsigned WPW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           call_req,
    input  logic           ret_req,
    output logic [WPW-1:0] cwp,
    output logic           ovf,
    output logic           unf
);
    localparam int unsigned DPW       = (NWIN > 2) ? $clog2(NWIN) : 1;
    localparam int unsigned DEPTH_MAX = NWIN - 1;

    typedef struct packed {
        logic [WPW-1:0] cwp;
        logic [DPW-1:0] depth;
    } ptr_t;

    ptr_t   st_d, st_q;
    wmove_e mv;

    always_comb begin
        st_d = st_q;
        ovf  = 1'b0;
        unf  = 1'b0;
        mv   = wmove_e'({call_req, ret_req});
        unique case (mv)
            WMOVE_CALL: begin
                if (st_q.depth == DPW'(DEPTH_MAX)) begin
                    ovf = 1'b1;
                end else begin
                    st_d.cwp   = st_q.cwp - 1'b1;
                    st_d.depth = st_q.depth + 1'b1;
                end
            end
            WMOVE_RET: begin
                if (st_q.depth == '0) begin
                    unf = 1'b1;
                end else begin
                    st_d.cwp   = st_q.cwp + 1'b1;
                    st_d.depth = st_q.depth - 1'b1;
                end
            end
            default: ; // none or both: hold
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp = st_q.cwp;
endmodule

// File: rtl/rwin_store.sv
// Physical storage: two combinational reads, one clocked write.
module rwin_store #(
    parameter int unsigned PHYS = 138,
    parameter int unsigned DW   = 32,
    parameter int unsigned PW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] wp,
    input  logic [DW-1:0] wd,
    input  logic [PW-1:0] rpa,
    input  logic [PW-1:0] rpb,
    output logic [DW-1:0] rda,
    output logic [DW-1:0] rdb
);
    logic [DW-1:0] mem_d [PHYS];
    logic [DW-1:0] mem_q [PHYS];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[wp] = wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(PHYS); i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rda = mem_q[rpa];
    assign rdb = mem_q[rpb];
endmodule

// File: rtl/rwin_file.sv
// Overlapped register window file, top level.
module rwin_file
    import rwin_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned NWIN   = DEF_NWIN,
    parameter int unsigned NGLOB  = DEF_NGLOB,
    parameter int unsigned NOVL   = DEF_NOVL,
    parameter int unsigned NLOC   = DEF_NLOC,
    localparam int unsigned LREGS = NGLOB + 2 * NOVL + NLOC,
    localparam int unsigned AW    = $clog2(LREGS),
    localparam int unsigned PHYS  = NGLOB + NWIN * (NLOC + NOVL),
    localparam int unsigned PW    = $clog2(PHYS),
    localparam int unsigned WPW   = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ra_sel,
    output logic [DATA_W-1:0] ra_data,
    input  logic [AW-1:0]     rb_sel,
    output logic [DATA_W-1:0] rb_data,
    input  logic              we,
    input  logic [AW-1:0]     wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              call_req,
    input  logic              ret_req,
    output logic [WPW-1:0]    win_ptr,
    output logic              win_ovf,
    output logic              win_unf
);
    localparam int NPORT = 3; // read A, read B, write

    logic [WPW-1:0] cwp;
    logic [AW-1:0]  lsel [NPORT];
    logic [PW-1:0]  psel [NPORT];

    assign lsel[0] = ra_sel;
    assign lsel[1] = rb_sel;
    assign lsel[2] = wsel;

    rwin_ptr #(.NWIN(NWIN), .WPW(WPW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_req (call_req),
        .ret_req  (ret_req),
        .cwp      (cwp),
        .ovf      (win_ovf),
        .unf      (win_unf)
    );

    // every port maps through the pre-move pointer (write included)
    for (genvar gi = 0; gi < NPORT; gi++) begin : g_map
        rwin_map #(
            .NWIN(NWIN), .NGLOB(NGLOB), .NOVL(NOVL), .NLOC(NLOC),
            .AW(AW), .PW(PW), .WPW(WPW)
        ) u_map (
            .cwp  (cwp),
            .lsel (lsel[gi]),
            .psel (psel[gi])
        );
    end

    rwin_store #(.PHYS(PHYS), .DW(DATA_W), .PW(PW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .wp    (psel[2]),
        .wd    (wdata),
        .rpa   (psel[0]),
        .rpb   (psel[1]),
        .rda   (ra_data),
        .rdb   (rb_data)
    );

    assign win_ptr = cwp;
endmodule

// File: rtl/rwin_chk.sv
module rwin_chk #(
    parameter int unsigned WPW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           call_req,
    input logic           ret_req,
    input logic [WPW-1:0] win_ptr,
    input logic           win_ovf,
    input logic           win_unf
);
    AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !ret_req && !win_ovf) |=> (win_ptr == WPW'($past(win_ptr) - 1'b1))); // R3
    AST_RET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req && !win_unf) |=> (win_ptr == WPW'($past(win_ptr) + 1'b1))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_req && !ret_req) |=> $stable(win_ptr)); // R3
    AST_NO_OVERFLOW_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        win_ovf |=> $stable(win_ptr)); // R6
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_ovf |-> (call_req && !ret_req)); // R6
    AST_NO_UNDERFLOW_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        win_unf |=> $stable(win_ptr)); // R7
    AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_unf |-> (ret_req && !call_req)); // R7
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && ret_req) |=> $stable(win_ptr)); // R11
endmodule

bind rwin_file rwin_chk #(.WPW(WPW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_req (call_req),
    .ret_req  (ret_req),
    .win_ptr  (win_ptr),
    .win_ovf  (win_ovf),
    .win_unf  (win_unf)
);

// File: tb/sim_rwin_file.sv
`timescale 1ns/1ps
module sim_rwin_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ra_sel = '0, rb_sel = '0, wsel = '0;
    logic [31:0] ra_data, rb_data, wdata = '0;
    logic        we = 1'b0, call_req = 1'b0, ret_req = 1'b0;
    logic [2:0]  win_ptr;
    logic        win_ovf, win_unf;

    always #2.5 clk = ~clk; // 200 MHz

    rwin_file u0 (
        .clk(clk), .rst_n(rst_n),
        .ra_sel(ra_sel), .ra_data(ra_data),
        .rb_sel(rb_sel), .rb_data(rb_data),
        .we(we), .wsel(wsel), .wdata(wdata),
        .call_req(call_req), .ret_req(ret_req),
        .win_ptr(win_ptr), .win_ovf(win_ovf), .win_unf(win_unf)
    );

    // scoreboard item: which output, expected value, requirement tag
    typedef struct {
        int          kind; // 0 ra,1 rb,2 ptr,3 ovf,4 unf
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    task automatic drive(bit c, bit r, bit w, logic [4:0] ws, logic [31:0] wd,
                         logic [4:0] a, logic [4:0] b);
        @(posedge clk);
        #1;
        call_req = c; ret_req = r; we = w;
        wsel = ws; wdata = wd; ra_sel = a; rb_sel = b;
    endtask

    task automatic idle(logic [4:0] a, logic [4:0] b);
        drive(1'b0, 1'b0, 1'b0, 5'd0, 32'd0, a, b);
    endtask

    task automatic wr(logic [4:0] ws, logic [31:0] wd);
        drive(1'b0, 1'b0, 1'b1, ws, wd, 5'd0, 5'd0);
    endtask

    task automatic expect_val(int kind, logic [31:0] v, string tag);
        item_t it;
        it.kind = kind; it.val = v; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compare away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = q.pop_front();
                case (it.kind)
                    0: got = ra_data;
                    1: got = rb_data;
                    2: got = {29'd0, win_ptr};
                    3: got = {31'd0, win_ovf};
                    default: got = {31'd0, win_unf};
                endcase
                total++;
                if (got !== it.val) begin
                    bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, got, it.val);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        idle(5'd5, 5'd20);
        expect_val(0, 32'd0, "R1"); expect_val(1, 32'd0, "R1");
        expect_val(2, 32'd0, "R1"); expect_val(3, 32'd0, "R1"); expect_val(4, 32'd0, "R1");

        // R7: return at depth zero
        drive(1'b0, 1'b1, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);
        expect_val(4, 32'd1, "R7");
        idle(5'd0, 5'd0);
        expect_val(2, 32'd0, "R7"); expect_val(4, 32'd0, "R7");

        // fill window 0
        wr(5'd3,  32'h0000_00A1);
        wr(5'd16, 32'h0000_0010);
        wr(5'd26, 32'h0000_0026);
        wr(5'd31, 32'h0000_0031);
        // R8: both ports read independently after the write edges
        idle(5'd3, 5'd16);
        expect_val(0, 32'h0000_00A1, "R8"); expect_val(1, 32'h0000_0010, "R8");

        // R9: write in the call cycle lands in window 0
        drive(1'b1, 1'b0, 1'b1, 5'd17, 32'h0000_0017, 5'd0, 5'd0);
        expect_val(3, 32'd0, "R6"); expect_val(2, 32'd0, "R3");

        // R10: wrap to 7; R4: incoming group sees caller's outgoing values
        idle(5'd10, 5'd15);
        expect_val(2, 32'd7, "R10");
        expect_val(0, 32'h0000_0026, "R4"); expect_val(1, 32'h0000_0031, "R4");
        // R2 global shared, R5 callee local fresh
        idle(5'd3, 5'd16);
        expect_val(0, 32'h0000_00A1, "R2"); expect_val(1, 32'd0, "R5");

        // callee activity
        wr(5'd16, 32'h0000_0BAD);
        wr(5'd11, 32'h0000_0111);
        wr(5'd10, 32'h0000_0222);
        // R9: write during return goes to window 7
        drive(1'b0, 1'b1, 1'b1, 5'd17, 32'h0000_0717, 5'd0, 5'd0);
        expect_val(2, 32'd7, "R3"); expect_val(4, 32'd0, "R7");

        idle(5'd16, 5'd17);
        expect_val(2, 32'd0, "R3");
        expect_val(0, 32'h0000_0010, "R5"); expect_val(1, 32'h0000_0017, "R9");
        idle(5'd27, 5'd26);
        expect_val(0, 32'h0000_0111, "R4"); expect_val(1, 32'h0000_0222, "R4");

        // back into window 7 to see the return-cycle write
        drive(1'b1, 1'b0, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);
        idle(5'd17, 5'd16);
        expect_val(0, 32'h0000_0717, "R9"); expect_val(1, 32'h0000_0BAD, "R5");

        // R11: call and return together
        drive(1'b1, 1'b1, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);
        expect_val(3, 32'd0, "R11"); expect_val(4, 32'd0, "R11");
        idle(5'd0, 5'd0);
        expect_val(2, 32'd7, "R11");
        // leave window 7, depth back to 0
        drive(1'b0, 1'b1, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);
        idle(5'd0, 5'd0);
        expect_val(2, 32'd0, "R3");

        // R6: seven calls fit, the eighth is refused
        for (int i = 0; i < 7; i++) begin
            drive(1'b1, 1'b0, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);
            expect_val(2, 32'((8 - i) % 8), "R3");
            expect_val(3, 32'd0, "R6");
        end
        drive(1'b1, 1'b0, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);
        expect_val(2, 32'd1, "R6"); expect_val(3, 32'd1, "R6");
        idle(5'd0, 5'd0);
        expect_val(2, 32'd1, "R6"); expect_val(3, 32'd0, "R6");

        // unwind, then R7 at zero depth again
        for (int i = 0; i < 7; i++) begin
            drive(1'b0, 1'b1, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);
            expect_val(4, 32'd0, "R7");
        end
        idle(5'd0, 5'd0);
        expect_val(2, 32'd0, "R3");
        drive(1'b0, 1'b1, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);
        expect_val(4, 32'd1, "R7");
        idle(5'd3, 5'd16);
        expect_val(2, 32'd0, "R7");
        expect_val(0, 32'h0000_00A1, "R2"); expect_val(1, 32'h0000_0010, "R5");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule